// File: doc/BRIEF.md
# Program Counter and Instruction Fetch Unit

This block holds the program counter of a single-cycle processor, reads the instruction word stored at the current PC from an internal read-only instruction store, and chooses the PC for the next cycle. The instruction word is available in the same cycle as the PC, so the decoder and datapath around the block can produce their flags within that cycle. Those flags come back as inputs: a flag saying the current instruction is a conditional branch, the ALU zero result, a flag saying it is an unconditional jump, and the 16-bit and 26-bit immediate fields of the current instruction.

The next PC is picked in two stages. The first stage chooses between the sequential address (PC + 4) and the PC-relative branch target. It takes the branch target only when the branch flag and the zero flag are both high. The second stage replaces that choice with the pseudo-direct jump target whenever the jump flag is high. The PC is always word aligned. The instruction store is indexed by the PC word address and wraps modulo its depth. Its contents are a fixed computed pattern, so the block needs no loading path.

Top module: `pc_fetch_unit`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, `pc_o` becomes 0x00000000 after that edge. This holds whatever the other inputs are.
- R2: When `jump_i` is 0 and the branch is not taken, `pc_o` advances by 4 at each rising edge.
- R3: When `br_inst_i` and `zero_i` are both 1 and `jump_i` is 0, the next `pc_o` is (`pc_o` + 4) + (sign-extended `imm16_i` × 4). The addition wraps modulo 2^32, so a negative `imm16_i` moves the PC backwards.
- R4: Either flag on its own gives the sequential address PC + 4 and does not take the branch. This covers `br_inst_i`=1 with `zero_i`=0, and `zero_i`=1 with `br_inst_i`=0.
- R5: When `jump_i` is 1, the next `pc_o` is {bits 31..28 of (`pc_o` + 4), `jtgt_i`[25:0], 2'b00}. This holds whatever `br_inst_i`, `zero_i` and `imm16_i` are.
- R6: The upper four bits of the jump target come from PC + 4, not from PC. A jump issued at 0x0FFFFFFC therefore lands in the region that starts at 0x10000000.
- R7: `instr_o` is a combinational read at the current `pc_o`. With i = `pc_o`[7:2] (word index modulo the default depth of 64), `instr_o` = {~i[15:0], i[15:0] ^ 16'h3C5A}, where i is zero-extended to 16 bits.
- R8: `pc_o`[1:0] is 2'b00 in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the PC updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| br_inst_i | input | 1 | The current instruction is a conditional branch |
| zero_i | input | 1 | ALU zero result for the current instruction |
| jump_i | input | 1 | The current instruction is an unconditional jump |
| imm16_i | input | 16 | Branch offset field, in words, signed |
| jtgt_i | input | 26 | Jump target field, in words |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction word stored at `pc_o` |

## Verification
The stimulus covers several cases. Runs of plain sequential steps check that the adder alone drives the PC. Taken branches with positive and negative offsets show that the offset is sign-extended, scaled by four and added to PC + 4. Branch-flag-only and zero-only cycles show that the select is an AND and not an OR. Jumps issued while a branch is also taken show that the jump stage has priority. A jump issued at 0x0FFFFFFC tells apart upper bits taken from PC + 4 and upper bits taken from PC. High addresses check that the instruction store wraps, and a reset asserted in the middle of a jump checks that reset overrides every other input.

// File: rtl/pcfetch_pkg.sv
// Package: shared widths and the instruction-store content function.
// Assumes a 32-bit byte-addressed PC with word-aligned instructions.
package pcfetch_pkg;

    localparam int PC_W  = 32;
    localparam int IMM_W = 16;
    localparam int JT_W  = 26;

    typedef logic [PC_W-1:0] addr_t;
    typedef logic [31:0]     word_t;

    // Content of word idx of the instruction store: inverted index above, seeded index below.
    function automatic word_t rom_word(input logic [31:0] idx, input logic [15:0] seed);
        logic [15:0] low;
        low = idx[15:0];
        return {~low, low ^ seed};
    endfunction

endpackage

// File: rtl/pc_reg.sv
// Module: pc_reg
// Holds the program counter and loads the chosen next PC on each rising edge.
// Assumes that next_pc is word aligned and that reset is synchronous and active low.
module pc_reg
    import pcfetch_pkg::*;
#(
    parameter addr_t RESET_PC = '0
) (
    input  logic  clk,
    input  logic  rst_n,
    input  addr_t next_pc,
    output addr_t pc_q
);

    // PC register: reset loads RESET_PC, otherwise the selected next address.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= next_pc;
    end

    // R1: a reset edge always leaves the reset address in the PC.
    p_reset_pc_r1: assert property (@(posedge clk) !rst_n |=> pc_q == RESET_PC)
        else $error("p_reset_pc_r1");

    // R8: the PC stays word aligned after reset.
    p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n) pc_q[1:0] == 2'b00)
        else $error("p_aligned_r8");

endmodule

// File: rtl/next_pc_logic.sv
// Module: next_pc_logic
// Builds the next PC in two stages: a branch stage (sequential or PC-relative)
// and a jump stage that overrides it. Purely combinational.
// Assumes the offset is in words and that the jump keeps the upper PC bits of PC + 4.
module next_pc_logic
    import pcfetch_pkg::*;
(
    input  addr_t            pc,
    input  logic             br_inst,
    input  logic             zero,
    input  logic             jump,
    input  logic [IMM_W-1:0] imm16,
    input  logic [JT_W-1:0]  jtgt,
    output addr_t            seq_pc,
    output addr_t            next_pc
);

    localparam int EXT_W = PC_W - IMM_W - 2;
    localparam int HI_W  = PC_W - JT_W - 2;

    addr_t branch_off;
    addr_t branch_pc;
    addr_t jump_pc;
    addr_t stage1_pc;
    logic  take_branch;

    // Sequential address and the scaled, sign-extended branch offset.
    always_comb begin
        seq_pc     = pc + addr_t'(4);
        branch_off = {{EXT_W{imm16[IMM_W-1]}}, imm16, 2'b00};
        branch_pc  = seq_pc + branch_off;
        jump_pc    = {seq_pc[PC_W-1 -: HI_W], jtgt, 2'b00};
    end

    // Branch stage: the select is the AND of the branch flag and the zero flag.
    always_comb begin
        take_branch = br_inst & zero;
        stage1_pc   = take_branch ? branch_pc : seq_pc;
    end

    // Jump stage: the jump flag overrides the branch stage.
    always_comb begin
        next_pc = jump ? jump_pc : stage1_pc;
    end

endmodule

// File: rtl/instr_rom.sv
// Module: instr_rom
// Read-only instruction store of DEPTH words filled from pcfetch_pkg::rom_word.
// Read is combinational. Assumes DEPTH is a power of two, so the index wraps.
module instr_rom
    import pcfetch_pkg::*;
#(
    parameter int          DEPTH = 64,
    parameter logic [15:0] SEED  = 16'h3C5A,
    localparam int         IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0] word_idx,
    output word_t            word
);

    word_t store [DEPTH];

    // One constant entry per word, computed at elaboration.
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign store[g] = rom_word(32'(g), SEED);
    end

    // Combinational read at the requested word.
    always_comb begin
        word = store[word_idx];
    end

endmodule

// File: rtl/pc_fetch_unit.sv
// Module: pc_fetch_unit (top)
// Program counter, instruction store and next-PC selection of a single-cycle core.
// Assumes that the flags and immediate fields are derived from instr_o in the same cycle.
module pc_fetch_unit
    import pcfetch_pkg::*;
#(
    parameter int          IMEM_WORDS = 64,
    parameter logic [15:0] ROM_SEED   = 16'h3C5A
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        br_inst_i,
    input  logic        zero_i,
    input  logic        jump_i,
    input  logic [15:0] imm16_i,
    input  logic [25:0] jtgt_i,
    output logic [31:0] pc_o,
    output logic [31:0] instr_o
);

    localparam int IDX_W = $clog2(IMEM_WORDS);

    addr_t pc_q;
    addr_t seq_pc;
    addr_t next_pc;

    pc_reg #(.RESET_PC('0)) u_pc (
        .clk     (clk),
        .rst_n   (rst_n),
        .next_pc (next_pc),
        .pc_q    (pc_q)
    );

    next_pc_logic u_next (
        .pc      (pc_q),
        .br_inst (br_inst_i),
        .zero    (zero_i),
        .jump    (jump_i),
        .imm16   (imm16_i),
        .jtgt    (jtgt_i),
        .seq_pc  (seq_pc),
        .next_pc (next_pc)
    );

    instr_rom #(.DEPTH(IMEM_WORDS), .SEED(ROM_SEED)) u_rom (
        .word_idx (pc_q[IDX_W+1:2]),
        .word     (instr_o)
    );

    assign pc_o = pc_q;

    // R2/R4: no jump and no taken branch gives exactly PC + 4.
    p_sequential_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_i && !(br_inst_i && zero_i)) |=> pc_o == $past(pc_o) + 32'd4)
        else $error("p_sequential_r2");

    // R4: a lone branch flag never redirects the PC.
    p_lone_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!jump_i && (br_inst_i != zero_i)) |=> pc_o == $past(seq_pc))
        else $error("p_lone_flag_r4");

    // R3: a taken branch adds the scaled signed offset to PC + 4.
    p_branch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_inst_i && zero_i && !jump_i) |=>
        pc_o == $past(pc_o) + 32'd4 + {{14{$past(imm16_i[15])}}, $past(imm16_i), 2'b00})
        else $error("p_branch_r3");

    // R5/R6: a jump loads the pseudo-direct target built on PC + 4.
    p_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
        jump_i |=> pc_o == {$past(seq_pc[31:28]), $past(jtgt_i), 2'b00})
        else $error("p_jump_r5");

endmodule

// File: tb/pc_fetch_unit_bench.sv
// Bench: behavioural reference model of the PC, compared on every clock.
module pc_fetch_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_inst_i = 1'b0;
    logic        zero_i = 1'b0;
    logic        jump_i = 1'b0;
    logic [15:0] imm16_i = '0;
    logic [25:0] jtgt_i = '0;
    logic [31:0] pc_o;
    logic [31:0] instr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model_pc = 32'd0;

    always #2 clk = ~clk;

    pc_fetch_unit u_pc_fetch_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .br_inst_i (br_inst_i),
        .zero_i    (zero_i),
        .jump_i    (jump_i),
        .imm16_i   (imm16_i),
        .jtgt_i    (jtgt_i),
        .pc_o      (pc_o),
        .instr_o   (instr_o)
    );

    // Expected instruction word for a PC (R7 rule).
    function automatic logic [31:0] exp_word(input logic [31:0] pc);
        logic [15:0] i;
        i = 16'((pc >> 2) % 64);
        return {~i, i ^ 16'h3C5A};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare outputs at the negative edge, drive one cycle, update the model at the edge.
    task automatic step(input string req, input logic rn, input logic b, input logic z,
                        input logic j, input logic [15:0] imm, input logic [25:0] t);
        logic [31:0] nxt;
        check({req, " pc"}, pc_o, model_pc);
        check("R7 instr", instr_o, exp_word(model_pc));
        check("R8 align", {30'd0, pc_o[1:0]}, 32'd0);
        rst_n = rn; br_inst_i = b; zero_i = z; jump_i = j; imm16_i = imm; jtgt_i = t;
        if (!rn)           nxt = 32'd0;
        else if (j)        nxt = {(model_pc + 32'd4) >> 28, 28'd0} | ({6'd0, t} << 2);
        else if (b && z)   nxt = model_pc + 32'd4 + 32'($signed(imm)) * 32'd4;
        else               nxt = model_pc + 32'd4;
        @(posedge clk);
        model_pc = nxt;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : stimulus
        @(negedge clk);
        step("R1 reset", 1'b0, 1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        step("R1 reset", 1'b0, 1'b1, 1'b1, 1'b1, 16'h7, 26'h5);
        check("R1 reset value", pc_o, 32'd0);
        for (int k = 0; k < 5; k++) step("R2 seq", 1'b1, 1'b0, 1'b0, 1'b0, 16'(k * 3), 26'h0);
        step("R3 branch fwd", 1'b1, 1'b1, 1'b1, 1'b0, 16'h0010, 26'h0);
        step("R2 seq", 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        step("R3 branch back", 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFF0, 26'h0);
        step("R3 branch self", 1'b1, 1'b1, 1'b1, 1'b0, 16'hFFFF, 26'h0);
        step("R4 br only", 1'b1, 1'b1, 1'b0, 1'b0, 16'h0100, 26'h0);
        step("R4 zero only", 1'b1, 1'b0, 1'b1, 1'b0, 16'h0100, 26'h0);
        step("R5 jump over branch", 1'b1, 1'b1, 1'b1, 1'b1, 16'h0040, 26'h0000123);
        step("R5 jump", 1'b1, 1'b0, 1'b0, 1'b1, 16'h0, 26'h3FFFFFF);
        check("R5 jump top", pc_o, 32'h0FFFFFFC);
        step("R6 jump upper", 1'b1, 1'b0, 1'b0, 1'b1, 16'h0, 26'h0000005);
        check("R6 region", pc_o, 32'h10000014);
        for (int k = 0; k < 70; k++) step("R7 wrap", 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        step("R3 branch wrap", 1'b1, 1'b1, 1'b1, 1'b0, 16'h8000, 26'h0);
        step("R2 seq", 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, 26'h0);
        step("R1 reset mid", 1'b0, 1'b0, 1'b0, 1'b1, 16'h0, 26'h2AAAAAA);
        step("R1 after reset", 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 26'h0);
        check("R1 after reset", pc_o, 32'd4);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule